// File: doc/BRIEF.md
# Bus Talker with Source Handshake and Identify Response

This block is the sending half of a general-purpose instrument bus port. It owns the three-wire source handshake and places one byte at a time, together with the end-of-message line, on the eight data lines. It watches the two acceptor lines, not-ready-for-data and not-data-accepted. Only one byte is offered at a time. A single origin selector chooses it from one of four places: the head of an outbound queue (either a controller command or a talker data byte), a serial-poll status byte, or one of two stored identity bytes.

Address recognition is done elsewhere and arrives as single-cycle strobes: own talk address, untalk, own secondary address, serial-poll enable and serial-poll disable. These strobes are qualified by the attention line. Besides the usual idle, addressed, serial-poll-active and active talker states, the block runs a six-step identify walk. The device must first be untalked and then receive its secondary address. When attention is released, it sends the first identity byte, waits for the handshake to return to idle, sends the second identity byte with end-of-message, and then parks in a completed step.

A bus-side acceptor, or a loopback model in test, drives the acceptor lines. The host side fills the queue and the identity registers, and presents the current status byte.

Top module: `gpib_talker`

## Requirements
- R1: After reset, DAV and EOI are low, the data lines read 0, the queue-full flag is low and the talker is idle, so no byte is offered even when the queue holds data and ATN is low.
- R2: A talk strobe taken while ATN is high addresses the talker. Releasing ATN then makes it active, and queued data bytes go out in write order. Any strobe that arrives while ATN is low has no effect.
- R3: A queue entry carries its byte in bits 7:0, an end flag in bit 8 (EOI goes high with that data byte) and a command flag in bit 9. The queue holds DEPTH entries. The full flag rises when it holds DEPTH, and a write made while full is dropped.
- R4: A command entry at the queue head is sent only while ATN is high, in any talker state, and always with EOI low. A data entry at the head is sent only by an active talker with ATN low. Either kind blocks the entries behind it.
- R5: DAV rises only when NRFD is low and only after the byte and EOI have been held on the lines for at least DLY_CYC clock cycles.
- R6: While DAV is high, the byte and EOI do not change. DAV stays high until NDAC goes low and then falls.
- R7: Serial-poll enable sets a mode flag and serial-poll disable clears it, both under ATN. An addressed talker with the flag set enters serial-poll-active when ATN drops, and on every handshake it sends the status byte input with EOI low.
- R8: When ATN rises, an active or serial-poll-active talker returns to addressed. A byte still in its settling phase is withdrawn without DAV, and a queue entry withdrawn this way stays queued.
- R9: The sequence untalk, then secondary address, then ATN low, sends the first identity byte with EOI low and then the second identity byte with EOI high. After that the talker sends nothing more until it is addressed again.
- R10: A secondary-address strobe that does not directly follow an untalk, for example one received while idle or addressed, is ignored.
- R11: The identity bytes are two registers written through id_we_i, with id_sel_i = 0 selecting the first and 1 the second. Writing one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| atn_i | input | 1 | Attention line, 1 = asserted |
| talk_stb_i | input | 1 | Own talk address received |
| untalk_stb_i | input | 1 | Untalk (or other talk address) received |
| sec_stb_i | input | 1 | Own secondary address received |
| spe_stb_i | input | 1 | Serial-poll enable received |
| spd_stb_i | input | 1 | Serial-poll disable received |
| nrfd_i | input | 1 | Not ready for data, 1 = asserted |
| ndac_i | input | 1 | Not data accepted, 1 = asserted |
| ofifo_we_i | input | 1 | Queue write strobe |
| ofifo_din_i | input | ENTRY_W | Queue entry: byte, end flag bit 8, command flag bit 9 |
| ofifo_full_o | output | 1 | Queue holds DEPTH entries |
| status_byte_i | input | 8 | Serial-poll status byte |
| id_we_i | input | 1 | Identity register write strobe |
| id_sel_i | input | 1 | 0 = first identity byte, 1 = second |
| id_din_i | input | 8 | Identity register write data |
| dav_o | output | 1 | Data valid, 1 = asserted |
| dio_o | output | 8 | Data lines, 0 when no byte is offered |
| eoi_o | output | 1 | End of message, 1 = asserted |

## Verification
The bench uses the default build: a queue depth of 8, 16-bit entries and a settling delay of 3 cycles. With a depth of 8, nine back-to-back writes reach the full condition and a dropped write. With the short delay, the random NRFD and NDAC hold-offs of the loopback acceptor fall both inside and beyond the settling window, so every transferred byte has its hold time measured. The same acceptor can be paused, which makes the withdrawal of a settling byte under ATN and the endless serial-poll repetition observable at the data lines.

// File: rtl/gpib_talker_pkg.sv
package gpib_talker_pkg;

  localparam int BYTE_W  = 8;
  localparam int TAG_END = 8;
  localparam int TAG_CMD = 9;

  typedef enum logic [3:0] {
    T_IDLE, T_ADDR, T_SPOLL, T_ACTIVE,
    T_ID_UNT, T_ID_SEC, T_ID_TX1, T_ID_WAIT, T_ID_TX2, T_ID_DONE
  } talk_st_t;

  typedef enum logic [1:0] {SH_IDLE, SH_DELAY, SH_XFER, SH_NEXT} sh_st_t;

  typedef enum logic [2:0] {
    ORG_NONE, ORG_CMD, ORG_DATA, ORG_SPOLL, ORG_ID1, ORG_ID2
  } org_t;

endpackage

// File: rtl/gpib_ofifo.sv
module gpib_ofifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, wptr_n, rptr, rptr_n;
  logic [CNT_W-1:0] count, count_n;
  logic             wr_ok, rd_ok;

  assign full_o  = (count == CNT_W'(DEPTH));
  assign empty_o = (count == '0);
  assign wr_ok   = we_i && !full_o;
  assign rd_ok   = pop_i && !empty_o;
  assign head_o  = mem[rptr];

  always_comb begin
    wptr_n  = wptr;
    rptr_n  = rptr;
    count_n = count;
    if (wr_ok) wptr_n = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    if (rd_ok) rptr_n = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    if (wr_ok && !rd_ok) count_n = count + 1'b1;
    else if (rd_ok && !wr_ok) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din_i;
  end

  a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/gpib_talk_fsm.sv
module gpib_talk_fsm
  import gpib_talker_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     atn_i,
  input  logic     talk_stb_i,
  input  logic     untalk_stb_i,
  input  logic     sec_stb_i,
  input  logic     spe_stb_i,
  input  logic     spd_stb_i,
  input  logic     xfer_done_i,
  input  org_t     xfer_org_i,
  input  logic     sh_idle_i,
  output talk_st_t st_o
);
  talk_st_t st, st_n;
  logic     spms, spms_n;

  assign st_o = st;

  always_comb begin
    st_n   = st;
    spms_n = spms;
    if (atn_i && spe_stb_i)      spms_n = 1'b1;
    else if (atn_i && spd_stb_i) spms_n = 1'b0;
    if (atn_i && talk_stb_i)        st_n = T_ADDR;
    else if (atn_i && untalk_stb_i) st_n = T_ID_UNT;
    else begin
      case (st)
        T_ADDR:            if (!atn_i) st_n = spms ? T_SPOLL : T_ACTIVE;
        T_ACTIVE, T_SPOLL: if (atn_i) st_n = T_ADDR;
        T_ID_UNT:          if (atn_i && sec_stb_i) st_n = T_ID_SEC;
        T_ID_SEC:          if (!atn_i) st_n = T_ID_TX1;
        T_ID_TX1:          if (xfer_done_i && xfer_org_i == ORG_ID1) st_n = T_ID_WAIT;
        T_ID_WAIT:         if (sh_idle_i && !atn_i) st_n = T_ID_TX2;
        T_ID_TX2:          if (xfer_done_i && xfer_org_i == ORG_ID2) st_n = T_ID_DONE;
        default:           ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= T_IDLE;
      spms <= 1'b0;
    end else begin
      st   <= st_n;
      spms <= spms_n;
    end
  end

  a_r7_spoll_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_SPOLL) |-> spms);
  a_r8_atn_returns_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(atn_i && (st == T_ACTIVE || st == T_SPOLL) && !untalk_stb_i) |-> (st == T_ADDR));
  a_r10_sec_only_after_untalk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_ID_SEC && $past(st) != T_ID_SEC) |-> ($past(st) == T_ID_UNT));

endmodule

// File: rtl/gpib_src_hs.sv
module gpib_src_hs
  import gpib_talker_pkg::*;
#(
  parameter int DLY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  org_t              sel_org_i,
  input  logic [BYTE_W-1:0] sel_byte_i,
  input  logic              sel_eoi_i,
  input  logic              nrfd_i,
  input  logic              ndac_i,
  output logic              dav_o,
  output logic [BYTE_W-1:0] dio_o,
  output logic              eoi_o,
  output logic              done_o,
  output org_t              done_org_o,
  output logic              idle_o
);
  localparam int CNT_W = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;

  sh_st_t            st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              load;
  logic [BYTE_W-1:0] lat_byte;
  logic              lat_eoi;
  org_t              lat_org;
  logic              driving;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    load  = 1'b0;
    case (st)
      SH_IDLE: if (sel_org_i != ORG_NONE) begin
        st_n  = SH_DELAY;
        load  = 1'b1;
        cnt_n = CNT_W'(DLY_CYC - 1);
      end
      SH_DELAY: begin
        if (sel_org_i != lat_org) st_n = SH_IDLE;
        else if (cnt == '0) begin
          if (!nrfd_i) st_n = SH_XFER;
        end else cnt_n = cnt - 1'b1;
      end
      SH_XFER: if (!ndac_i) st_n = SH_NEXT;
      default: st_n = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      cnt     <= '0;
      lat_byte <= '0;
      lat_eoi <= 1'b0;
      lat_org <= ORG_NONE;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      if (load) begin
        lat_byte <= sel_byte_i;
        lat_eoi  <= sel_eoi_i;
        lat_org  <= sel_org_i;
      end
    end
  end

  assign driving    = (st == SH_DELAY) || (st == SH_XFER);
  assign dav_o      = (st == SH_XFER);
  assign dio_o      = driving ? lat_byte : '0;
  assign eoi_o      = driving && lat_eoi;
  assign done_o     = (st == SH_XFER) && !ndac_i;
  assign done_org_o = lat_org;
  assign idle_o     = (st == SH_IDLE);

  a_r5_dav_waits_nrfd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_o) |-> !$past(nrfd_i));
  a_r5_dav_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_o) |-> $past(cnt == '0));
  a_r6_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dav_o && $past(dav_o)) |-> ($stable(dio_o) && $stable(eoi_o)));
  a_r6_release_on_ndac: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_o) |-> !$past(ndac_i));

endmodule

// File: rtl/gpib_talker.sv
module gpib_talker
  import gpib_talker_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ENTRY_W = 16,
  parameter int DLY_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               atn_i,
  input  logic               talk_stb_i,
  input  logic               untalk_stb_i,
  input  logic               sec_stb_i,
  input  logic               spe_stb_i,
  input  logic               spd_stb_i,
  input  logic               nrfd_i,
  input  logic               ndac_i,
  input  logic               ofifo_we_i,
  input  logic [ENTRY_W-1:0] ofifo_din_i,
  output logic               ofifo_full_o,
  input  logic [7:0]         status_byte_i,
  input  logic               id_we_i,
  input  logic               id_sel_i,
  input  logic [7:0]         id_din_i,
  output logic               dav_o,
  output logic [7:0]         dio_o,
  output logic               eoi_o
);
  logic [ENTRY_W-1:0] head;
  logic               q_empty, pop;
  logic               unused_head_bits;
  logic [7:0]         id_first, id_second;
  talk_st_t           t_st;
  org_t               sel_org, hs_org;
  logic [7:0]         sel_byte;
  logic               sel_eoi, hs_done, hs_idle;

  assign unused_head_bits = ^head[ENTRY_W-1:TAG_CMD+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_first  <= '0;
      id_second <= '0;
    end else begin
      if (id_we_i && !id_sel_i) id_first  <= id_din_i;
      if (id_we_i &&  id_sel_i) id_second <= id_din_i;
    end
  end

  always_comb begin
    sel_org = ORG_NONE;
    if (atn_i) begin
      if (!q_empty && head[TAG_CMD]) sel_org = ORG_CMD;
    end else begin
      case (t_st)
        T_SPOLL:  sel_org = ORG_SPOLL;
        T_ID_TX1: sel_org = ORG_ID1;
        T_ID_TX2: sel_org = ORG_ID2;
        T_ACTIVE: if (!q_empty && !head[TAG_CMD]) sel_org = ORG_DATA;
        default:  sel_org = ORG_NONE;
      endcase
    end
  end

  always_comb begin
    sel_byte = head[BYTE_W-1:0];
    sel_eoi  = 1'b0;
    case (sel_org)
      ORG_DATA:  sel_eoi  = head[TAG_END];
      ORG_SPOLL: sel_byte = status_byte_i;
      ORG_ID1:   sel_byte = id_first;
      ORG_ID2: begin
        sel_byte = id_second;
        sel_eoi  = 1'b1;
      end
      default: ;
    endcase
  end

  assign pop = hs_done && (hs_org == ORG_CMD || hs_org == ORG_DATA);

  gpib_ofifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .we_i(ofifo_we_i), .din_i(ofifo_din_i),
    .pop_i(pop), .head_o(head), .empty_o(q_empty), .full_o(ofifo_full_o)
  );

  gpib_talk_fsm u_talk (
    .clk(clk), .rst_n(rst_n), .atn_i(atn_i), .talk_stb_i(talk_stb_i),
    .untalk_stb_i(untalk_stb_i), .sec_stb_i(sec_stb_i), .spe_stb_i(spe_stb_i),
    .spd_stb_i(spd_stb_i), .xfer_done_i(hs_done), .xfer_org_i(hs_org),
    .sh_idle_i(hs_idle), .st_o(t_st)
  );

  gpib_src_hs #(.DLY_CYC(DLY_CYC)) u_sh (
    .clk(clk), .rst_n(rst_n), .sel_org_i(sel_org), .sel_byte_i(sel_byte),
    .sel_eoi_i(sel_eoi), .nrfd_i(nrfd_i), .ndac_i(ndac_i), .dav_o(dav_o),
    .dio_o(dio_o), .eoi_o(eoi_o), .done_o(hs_done), .done_org_o(hs_org),
    .idle_o(hs_idle)
  );

  a_r9_second_id_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (dav_o && t_st == T_ID_TX2 && hs_org == ORG_ID2) |-> eoi_o);
  a_r4_command_no_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (dav_o && hs_org == ORG_CMD) |-> !eoi_o);
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ofifo_full_o && !pop) |=> ofifo_full_o);

endmodule

// File: tb/gpib_talker_tb.sv
module gpib_talker_tb;
  localparam int CLK_NS  = 10;
  localparam int DEPTH   = 8;
  localparam int ENTRY_W = 16;
  localparam int DLY     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic atn, talk, unt, sec, spe, spd, nrfd, ndac, we, full, id_we, id_sel;
  logic [ENTRY_W-1:0] din;
  logic [7:0] stb, id_din, dio;
  logic dav, eoi;
  logic acc_en;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpib_talker #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .DLY_CYC(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .atn_i(atn), .talk_stb_i(talk), .untalk_stb_i(unt),
    .sec_stb_i(sec), .spe_stb_i(spe), .spd_stb_i(spd), .nrfd_i(nrfd), .ndac_i(ndac),
    .ofifo_we_i(we), .ofifo_din_i(din), .ofifo_full_o(full), .status_byte_i(stb),
    .id_we_i(id_we), .id_sel_i(id_sel), .id_din_i(id_din), .dav_o(dav),
    .dio_o(dio), .eoi_o(eoi)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Loopback acceptor with random hold-offs; measures settling time (R5) and DAV hold (R6).
  initial begin : acceptor
    int ph, cnt, settle;
    ph = 0; cnt = 0; settle = 0;
    nrfd = 1'b1; ndac = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ph = 0; cnt = 0; settle = 0; nrfd = 1'b1; ndac = 1'b1;
      end else begin
        if (!dav && dio != 8'h00) settle++;
        else if (dio == 8'h00) settle = 0;
        case (ph)
          0: if (acc_en) begin cnt = int'($urandom % 5); ph = 1; end
          1: if (!acc_en) ph = 0;
             else if (cnt == 0) begin nrfd = 1'b0; ph = 2; end
             else cnt--;
          2: if (dav) begin
               got_q.push_back({eoi, dio});
               chk(settle >= DLY, "R5 settle cycles", settle, DLY);
               nrfd = 1'b1;
               cnt = int'($urandom % 4);
               ph = 3;
             end else if (!acc_en) begin
               nrfd = 1'b1; ph = 0;
             end
          3: begin
               chk(dav == 1'b1, "R6 dav held before ndac release", int'(dav), 1);
               if (cnt == 0) begin ndac = 1'b0; ph = 4; end
               else cnt--;
             end
          default: if (!dav) begin ndac = 1'b1; ph = 0; end
        endcase
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit cmd, bit e, logic [7:0] b);
    we = 1'b1;
    din = '0;
    din[9] = cmd;
    din[8] = e;
    din[7:0] = b;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(int which);
    case (which)
      0: talk = 1'b1;
      1: unt = 1'b1;
      2: sec = 1'b1;
      3: spe = 1'b1;
      default: spd = 1'b1;
    endcase
    @(negedge clk);
    talk = 1'b0; unt = 1'b0; sec = 1'b0; spe = 1'b0; spd = 1'b0;
  endtask

  task automatic load_id(bit which, logic [7:0] v);
    id_we = 1'b1; id_sel = which; id_din = v;
    @(negedge clk);
    id_we = 1'b0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < 3000 && got_q.size() < n; i++) @(negedge clk);
    tick(30);
  endtask

  task automatic check_stream(string req);
    n_chk++;
    if (got_q.size() != exp_q.size()) begin
      n_bad++;
      $display("FAIL %s: byte count actual %0d expected %0d", req, got_q.size(), exp_q.size());
    end
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      n_chk++;
      if (got_q[i] !== exp_q[i]) begin
        n_bad++;
        $display("FAIL %s: item %0d actual eoi=%b byte=%02h expected eoi=%b byte=%02h",
                 req, i, got_q[i][8], got_q[i][7:0], exp_q[i][8], exp_q[i][7:0]);
      end
    end
    got_q.delete();
    exp_q.delete();
  endtask

  function automatic logic [7:0] rbyte();
    return 8'(1 + ($urandom % 255));
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin : watchdog
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] b, s, i1, i2;
    bit e;
    int n;
    void'($urandom(32'd4242));
    atn = 0; talk = 0; unt = 0; sec = 0; spe = 0; spd = 0;
    we = 0; din = '0; stb = 8'h41; id_we = 0; id_sel = 0; id_din = '0;
    acc_en = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk(dav == 1'b0, "R1 dav", int'(dav), 0);
    chk(dio == 8'h00, "R1 dio", int'(dio), 0);
    chk(eoi == 1'b0, "R1 eoi", int'(eoi), 0);
    chk(full == 1'b0, "R1 full", int'(full), 0);

    // R1/R2: idle talker sends nothing, strobe under ATN low ignored
    for (int k = 0; k < 3; k++) begin
      b = rbyte(); push(1'b0, 1'b0, b); exp_q.push_back({1'b0, b});
    end
    pulse(0);
    tick(40);
    chk(got_q.size() == 0, "R2 talk strobe with ATN low", got_q.size(), 0);
    atn = 1'b1; tick(1); pulse(0); atn = 1'b0;
    wait_n(3);
    check_stream("R2");

    // R3/R5/R6: random data bursts with random end flags
    for (int r = 0; r < 5; r++) begin
      n = 1 + int'($urandom % 8);
      for (int k = 0; k < n; k++) begin
        b = rbyte(); e = 1'($urandom % 2);
        push(1'b0, e, b); exp_q.push_back({e, b});
      end
      wait_n(n);
      check_stream("R3");
    end

    // R3: fill to full, ninth write dropped
    atn = 1'b1; tick(2);
    for (int k = 0; k < DEPTH + 1; k++) begin
      b = rbyte(); e = 1'($urandom % 2);
      push(1'b0, e, b);
      if (k < DEPTH) exp_q.push_back({e, b});
    end
    chk(full == 1'b1, "R3 full flag", int'(full), 1);
    atn = 1'b0;
    wait_n(DEPTH + 1);
    check_stream("R3");
    chk(full == 1'b0, "R3 full clears", int'(full), 0);

    // R4: commands under ATN, EOI low, data behind them blocks
    atn = 1'b1; tick(2);
    b = rbyte(); push(1'b1, 1'b0, b); exp_q.push_back({1'b0, b});
    b = rbyte(); push(1'b1, 1'b1, b); exp_q.push_back({1'b0, b});
    b = rbyte(); push(1'b0, 1'b0, b);
    wait_n(3);
    check_stream("R4");
    exp_q.push_back({1'b0, b});
    atn = 1'b0;
    wait_n(1);
    check_stream("R4");

    // R5/R8: byte settling behind NRFD, withdrawn by ATN, kept queued
    acc_en = 1'b0; tick(10);
    b = rbyte(); push(1'b0, 1'b1, b);
    tick(20);
    chk(dav == 1'b0, "R5 dav low while NRFD high", int'(dav), 0);
    atn = 1'b1; tick(2); acc_en = 1'b1;
    tick(40);
    chk(got_q.size() == 0, "R8 withdrawn byte not sent", got_q.size(), 0);
    exp_q.push_back({1'b1, b});
    atn = 1'b0;
    wait_n(1);
    check_stream("R8");

    // R7: serial poll repeats status byte
    s = rbyte(); stb = s;
    atn = 1'b1; tick(1); pulse(3); atn = 1'b0;
    for (int i = 0; i < 3000 && got_q.size() < 3; i++) @(negedge clk);
    acc_en = 1'b0; tick(20); atn = 1'b1; tick(5);
    chk(got_q.size() >= 3, "R7 repeated status bytes", got_q.size(), 3);
    foreach (got_q[k]) chk(got_q[k] === {1'b0, s}, "R7 status byte", int'(got_q[k]), int'({1'b0, s}));
    got_q.delete();
    acc_en = 1'b1;
    pulse(4);
    b = rbyte(); push(1'b0, 1'b0, b); exp_q.push_back({1'b0, b});
    atn = 1'b0;
    wait_n(1);
    check_stream("R7");

    // R10: secondary address while addressed is ignored
    atn = 1'b1; tick(1); pulse(2); atn = 1'b0;
    b = rbyte(); push(1'b0, 1'b0, b); exp_q.push_back({1'b0, b});
    wait_n(1);
    check_stream("R10");

    // R10: secondary address right after reset is ignored
    do_reset();
    load_id(1'b0, rbyte()); load_id(1'b1, rbyte());
    atn = 1'b1; tick(1); pulse(2); atn = 1'b0;
    tick(50);
    chk(got_q.size() == 0, "R10 sec from idle", got_q.size(), 0);

    // R9: identify walk
    i1 = rbyte(); i2 = rbyte();
    load_id(1'b0, i1); load_id(1'b1, i2);
    atn = 1'b1; tick(1); pulse(1); pulse(2); atn = 1'b0;
    exp_q.push_back({1'b0, i1}); exp_q.push_back({1'b1, i2});
    wait_n(2); tick(40);
    check_stream("R9");

    // R11: rewrite only the first identity byte
    i1 = rbyte(); load_id(1'b0, i1);
    atn = 1'b1; tick(1); pulse(1); pulse(2); atn = 1'b0;
    exp_q.push_back({1'b0, i1}); exp_q.push_back({1'b1, i2});
    wait_n(2); tick(40);
    check_stream("R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule